// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts conditional branch direction by running two different predictors side by side and letting a per-branch selector pick between them. The first predictor keeps one shift register of recent branch outcomes across the whole program and uses it to address a table of 2-bit counters. The second predictor works in two levels. It first reads the outcome history of the branch at hand from a table addressed by the branch address. That pattern then addresses a table of 3-bit counters. A third table of 2-bit counters, addressed by the branch address, holds a selector. The selector learns which of the two predictors has been more reliable for that branch.

The prediction is combinational from the fetch address and the current state. Together with the direction, the block returns the global history and the local pattern it used. When the branch resolves, the pipeline sends back its address, its real outcome and those two saved values. On the next clock edge the block then trains exactly the entries that produced the prediction, and it shifts the outcome into both histories.

Top module: `tourn_bpred`

## Requirements
- R1: After reset every counter sits at its weak not-taken value: 1 for the 2-bit counters, 3 for the 3-bit counters. Every selector sits at 1 (weak preference for the global side). The global history and all local histories are zero. So `pred_taken`, `pred_global`, `pred_local` and `pred_use_local` are 0, and `pred_ghist` and `pred_lpat` are 0, for any fetch address.
- R2: `pred_global` is 1 exactly when the 2-bit global counter addressed by the current global history (which is also output on `pred_ghist`) holds 2 or more.
- R3: `pred_lpat` is the local history entry addressed by fetch address bits [11:2]. `pred_local` is 1 exactly when the 3-bit counter addressed by that pattern holds 4 or more.
- R4: The selector is addressed by fetch address bits [13:2]. A value of 2 or 3 sets `pred_use_local` and makes `pred_taken` follow `pred_local`. A value of 0 or 1 makes `pred_taken` follow `pred_global`.
- R5: On a resolve, the selector of the resolved address moves by one toward the component that matched the outcome, and only when the two components (read at the saved indices) disagreed. Otherwise it is unchanged. It saturates at 0 and 3.
- R6: On a resolve, the global counter at the saved history and the local counter at the saved pattern each step up on taken and down on not-taken. The 2-bit counter saturates at 0 and 3, and the 3-bit counter at 0 and 7.
- R7: On a resolve, the global history shifts left and takes the outcome (1 = taken) into bit 0.
- R8: On a resolve, the local history entry for the resolved address shifts left and takes the outcome into bit 0.
- R9: Counter training uses the history and pattern returned with the resolve, not the current histories. This holds even when other branches resolved between prediction and resolve.
- R10: While `res_valid` is low, no state changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_global | output | 1 | Direction from the global-history component |
| pred_local | output | 1 | Direction from the local-history component |
| pred_use_local | output | 1 | Selector chose the local component |
| pred_ghist | output | 12 | Global history used for this prediction |
| pred_lpat | output | 10 | Local pattern used for this prediction |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Real outcome of the resolved branch |
| res_ghist | input | 12 | Global history saved at prediction time |
| res_lpat | input | 10 | Local pattern saved at prediction time |

## Verification
The bench drives a strict loop pattern (three taken, one not-taken), an alternating branch, and a pseudo-random mix of several branches. These cases force the selector to swing both ways. A selector that moved when both components agreed, or moved the wrong way, would show the wrong choice on `pred_use_local` within a few iterations. Long runs of one outcome drive every counter into saturation, where a missing clamp would wrap around and flip the prediction. In one test a branch resolves late, after another branch has already changed the global history; a design that trained with the live history would then drift from the expected tables. Garbage on the resolve inputs while `res_valid` is low must leave every later prediction unchanged.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    typedef enum logic {
        SRC_GLOBAL = 1'b0,
        SRC_LOCAL  = 1'b1
    } pred_src_e;

    // Verdict on one resolved branch, used to steer the selector.
    typedef struct packed {
        logic fire;      // resolve present
        logic glob_hit;  // global component matched outcome
        logic loc_hit;   // local component matched outcome
    } verdict_t;

    // Saturating step of an unsigned counter of width w (w <= 8).
    function automatic logic [7:0] sat_step(input logic [7:0] v,
                                            input logic up,
                                            input int unsigned w);
        logic [7:0] top;
        top = 8'((9'd1 << w) - 9'd1);
        if (up)
            return (v == top) ? v : v + 8'd1;
        else
            return (v == 8'd0) ? v : v - 8'd1;
    endfunction

    function automatic pred_src_e pick_src(input logic sel_msb);
        return sel_msb ? SRC_LOCAL : SRC_GLOBAL;
    endfunction

endpackage

// File: rtl/tourn_ctr_table.sv
module tourn_ctr_table
    import tourn_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic [IDX_W-1:0] trn_idx,
    output logic [CTR_W-1:0] trn_ctr,
    input  logic             trn_en,
    input  logic             trn_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] WEAK_LOW = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [7:0]       nxt;

    assign rd_ctr  = mem[rd_idx];
    assign trn_ctr = mem[trn_idx];

    always_comb nxt = sat_step(8'(trn_ctr), trn_up, CTR_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= WEAK_LOW;
        end else if (trn_en) begin
            mem[trn_idx] <= nxt[CTR_W-1:0];
        end
    end
endmodule

// File: rtl/tourn_hist_table.sv
module tourn_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              sh_en,
    input  logic [IDX_W-1:0]  sh_idx,
    input  logic              sh_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    assign rd_hist = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (sh_en) begin
            mem[sh_idx] <= {mem[sh_idx][HIST_W-2:0], sh_bit};
        end
    end
endmodule

// File: rtl/tourn_bpred.sv
module tourn_bpred
    import tourn_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int SEL_IDX_W = 12,
    parameter int GH_W      = 12,
    parameter int LHT_IDX_W = 10,
    parameter int LH_W      = 10,
    parameter int GCTR_W    = 2,
    parameter int LCTR_W    = 3,
    parameter int SEL_W     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_global,
    output logic            pred_local,
    output logic            pred_use_local,
    output logic [GH_W-1:0] pred_ghist,
    output logic [LH_W-1:0] pred_lpat,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [GH_W-1:0] res_ghist,
    input  logic [LH_W-1:0] res_lpat
);
    logic [GH_W-1:0]      ghr;
    logic [SEL_IDX_W-1:0] f_sel_idx, r_sel_idx;
    logic [LHT_IDX_W-1:0] f_lht_idx, r_lht_idx;
    logic [LH_W-1:0]      f_pat;
    logic [GCTR_W-1:0]    g_rd, g_trn;
    logic [LCTR_W-1:0]    l_rd, l_trn;
    logic [SEL_W-1:0]     s_rd, s_trn;
    verdict_t             vd;
    pred_src_e            src;

    assign f_sel_idx = fetch_pc[PC_LSB +: SEL_IDX_W];
    assign r_sel_idx = res_pc[PC_LSB +: SEL_IDX_W];
    assign f_lht_idx = fetch_pc[PC_LSB +: LHT_IDX_W];
    assign r_lht_idx = res_pc[PC_LSB +: LHT_IDX_W];

    // Global history register
    always_ff @(posedge clk) begin
        if (rst)
            ghr <= '0;
        else if (res_valid)
            ghr <= {ghr[GH_W-2:0], res_taken};
    end

    tourn_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LH_W)) u_lht (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (f_lht_idx),
        .rd_hist(f_pat),
        .sh_en  (res_valid),
        .sh_idx (r_lht_idx),
        .sh_bit (res_taken)
    );

    tourn_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W)) u_gtab (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ghr),
        .rd_ctr (g_rd),
        .trn_idx(res_ghist),
        .trn_ctr(g_trn),
        .trn_en (res_valid),
        .trn_up (res_taken)
    );

    tourn_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W)) u_ltab (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (f_pat),
        .rd_ctr (l_rd),
        .trn_idx(res_lpat),
        .trn_ctr(l_trn),
        .trn_en (res_valid),
        .trn_up (res_taken)
    );

    // Selector only learns when the two components disagreed.
    always_comb begin
        vd.fire     = res_valid;
        vd.glob_hit = (g_trn[GCTR_W-1] == res_taken);
        vd.loc_hit  = (l_trn[LCTR_W-1] == res_taken);
    end

    tourn_ctr_table #(.IDX_W(SEL_IDX_W), .CTR_W(SEL_W)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (f_sel_idx),
        .rd_ctr (s_rd),
        .trn_idx(r_sel_idx),
        .trn_ctr(s_trn),
        .trn_en (vd.fire && (vd.glob_hit != vd.loc_hit)),
        .trn_up (vd.loc_hit)
    );

    assign src            = pick_src(s_rd[SEL_W-1]);
    assign pred_global    = g_rd[GCTR_W-1];
    assign pred_local     = l_rd[LCTR_W-1];
    assign pred_use_local = (src == SRC_LOCAL);
    assign pred_taken     = (src == SRC_LOCAL) ? pred_local : pred_global;
    assign pred_ghist     = ghr;
    assign pred_lpat      = f_pat;
endmodule

// File: rtl/tourn_bpred_chk.sv
module tourn_bpred_chk #(
    parameter int PC_W = 32,
    parameter int GH_W = 12,
    parameter int LH_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic            pred_taken,
    input logic            pred_use_local,
    input logic [GH_W-1:0] pred_ghist,
    input logic [LH_W-1:0] pred_lpat
);
    // R1: out of reset nothing predicts taken and history is clear
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!pred_taken && !pred_use_local && pred_ghist == '0));

    // R7: each resolve shifts its outcome into the global history
    assert_ghist_shift_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> pred_ghist == {$past(pred_ghist[GH_W-2:0]), $past(res_taken)});

    // R8: resolving the fetched branch shifts its own local pattern
    assert_lhist_shift_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pc == fetch_pc) ##1 $stable(fetch_pc)
        |-> pred_lpat == {$past(pred_lpat[LH_W-2:0]), $past(res_taken)});

    // R10: with no resolve and a steady fetch address nothing moves
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid ##1 $stable(fetch_pc)
        |-> ($stable(pred_taken) && $stable(pred_use_local)
             && $stable(pred_ghist) && $stable(pred_lpat)));
endmodule

bind tourn_bpred tourn_bpred_chk #(.PC_W(PC_W), .GH_W(GH_W), .LH_W(LH_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fetch_pc      (fetch_pc),
    .res_valid     (res_valid),
    .res_pc        (res_pc),
    .res_taken     (res_taken),
    .pred_taken    (pred_taken),
    .pred_use_local(pred_use_local),
    .pred_ghist    (pred_ghist),
    .pred_lpat     (pred_lpat)
);

// File: tb/tb_tourn_bpred.sv
`timescale 1ns/1ps
module tb_tourn_bpred;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_global, pred_local, pred_use_local;
    logic [11:0] pred_ghist;
    logic [9:0]  pred_lpat;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [11:0] res_ghist = '0;
    logic [9:0]  res_lpat = '0;

    always #2 clk = ~clk;

    tourn_bpred dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_global(pred_global),
        .pred_local(pred_local), .pred_use_local(pred_use_local),
        .pred_ghist(pred_ghist), .pred_lpat(pred_lpat),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_ghist(res_ghist), .res_lpat(res_lpat)
    );

    // Reference model of the tables, built from the requirements
    int sel_m [4096];
    int gct_m [4096];
    int lct_m [1024];
    int lht_m [1024];
    int gh_m;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        int tk; int gl; int lo; int us; int gh; int lp; string tag;
    } exp_t;
    exp_t exp_q [$];
    event mon_ev;

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic check(bit ok, string req, int act, int expv, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected items and compares with the outputs
    always @(mon_ev) begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(pred_ghist) == e.gh, "R7", int'(pred_ghist), e.gh, {e.tag, " ghist"});
        check(int'(pred_lpat) == e.lp, "R8", int'(pred_lpat), e.lp, {e.tag, " lpat"});
        check(int'(pred_global) == e.gl, "R2", int'(pred_global), e.gl, {e.tag, " global"});
        check(int'(pred_local) == e.lo, "R3", int'(pred_local), e.lo, {e.tag, " local"});
        check(int'(pred_use_local) == e.us, "R5", int'(pred_use_local), e.us, {e.tag, " select"});
        check(int'(pred_taken) == e.tk, "R4", int'(pred_taken), e.tk, {e.tag, " final"});
    end

    // Driver: present a fetch, push the model's expectation
    task automatic predict(input logic [31:0] pc, input string tag,
                           output int gs, output int ls);
        exp_t e;
        int li, ci;
        @(negedge clk);
        fetch_pc = pc;
        li = int'(pc[11:2]);
        ci = int'(pc[13:2]);
        e.gh = gh_m;
        e.lp = lht_m[li];
        e.gl = (gct_m[gh_m] >= 2) ? 1 : 0;
        e.lo = (lct_m[e.lp] >= 4) ? 1 : 0;
        e.us = (sel_m[ci] >= 2) ? 1 : 0;
        e.tk = e.us ? e.lo : e.gl;
        e.tag = tag;
        gs = e.gh;
        ls = e.lp;
        #1;
        exp_q.push_back(e);
        -> mon_ev;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input bit tk, input int gs, input int ls);
        int li, ci, gp, lp;
        @(negedge clk);
        res_valid = 1'b1;
        res_pc    = pc;
        res_taken = tk;
        res_ghist = 12'(gs);
        res_lpat  = 10'(ls);
        @(posedge clk);
        li = int'(pc[11:2]);
        ci = int'(pc[13:2]);
        gp = (gct_m[gs] >= 2) ? 1 : 0;
        lp = (lct_m[ls] >= 4) ? 1 : 0;
        gct_m[gs] = sat(gct_m[gs], tk, 3);
        lct_m[ls] = sat(lct_m[ls], tk, 7);
        if (gp != lp) sel_m[ci] = sat(sel_m[ci], (lp == int'(tk)), 3);
        lht_m[li] = ((lht_m[li] << 1) | int'(tk)) & 1023;
        gh_m = ((gh_m << 1) | int'(tk)) & 4095;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic branch(input logic [31:0] pc, input bit tk, input string tag);
        int gs, ls;
        predict(pc, tag, gs, ls);
        resolve(pc, tk, gs, ls);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        int gx, lx, gy, ly;
        for (int i = 0; i < 4096; i++) begin sel_m[i] = 1; gct_m[i] = 1; end
        for (int i = 0; i < 1024; i++) begin lct_m[i] = 3; lht_m[i] = 0; end
        gh_m = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state at two unrelated addresses
        predict(32'h0000_1000, "R1 reset", gx, lx);
        predict(32'h0000_ABC4, "R1 reset", gx, lx);
        check(pred_taken == 1'b0, "R1", int'(pred_taken), 0, "reset final");

        // R6 R5: loop branch, three taken then one not taken
        for (int k = 0; k < 24; k++)
            branch(32'h0000_1000, (k % 4) != 3, "R6 loop");

        // R3 R8: alternating branch
        for (int k = 0; k < 24; k++)
            branch(32'h0000_2040, k[0], "R8 alternate");

        // R6: saturation with a long taken run then a long not-taken run
        for (int k = 0; k < 12; k++) branch(32'h0000_3008, 1'b1, "R6 sat up");
        for (int k = 0; k < 12; k++) branch(32'h0000_3008, 1'b0, "R6 sat down");

        // R9: late resolve after another branch changed the histories
        predict(32'h0000_400C, "R9 early", gx, lx);
        predict(32'h0000_5010, "R9 other", gy, ly);
        resolve(32'h0000_5010, 1'b1, gy, ly);
        resolve(32'h0000_400C, 1'b0, gx, lx);
        predict(32'h0000_400C, "R9 after", gx, lx);
        predict(32'h0000_5010, "R9 after", gy, ly);

        // R10: garbage on resolve inputs with valid low
        @(negedge clk);
        res_pc = 32'h0000_1000; res_taken = 1'b1;
        res_ghist = 12'hFFF; res_lpat = 10'h3FF;
        repeat (5) @(negedge clk);
        predict(32'h0000_1000, "R10 idle", gx, lx);
        predict(32'h0000_3008, "R10 idle", gx, lx);

        // R4 R5: pseudo-random mix over eight branches
        lf = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] pc;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pc = 32'h0000_6000 + {27'd0, lf[2:0], 2'b00} * 32'd68;
            branch(pc, lf[3] ^ lf[0] ^ (k % 3 == 0), "R4 mix");
        end

        finish_run();
    end
endmodule